// File: doc/BRIEF.md
# Frame-Clock Ratio Detector and Sync Monitor

This block runs on the system clock of a sampling converter that receives its frame clock from outside. It counts system-clock cycles between rising frame-clock edges and works out which of four system-clock-to-sample-rate ratios is present: 256, 384, 512 or 768. Once a ratio has been seen on two consecutive frames it declares lock. From that ratio it produces two clock enables, at 128 and at 64 times the sample rate, for the filter and the modulator. The enables restart at every frame edge.

While locked, the block compares each measured frame length with the locked ratio. The allowed shift is expressed in bit-clock periods, so it depends on whether a frame carries 64 or 48 bit clocks. Small shifts are absorbed. Large shifts, including a frame clock that stops, drop lock within one frame. Shifts in between leave the lock state as it is. Whenever the block is unlocked it asks downstream logic to send zero samples. After each new lock it keeps that request up for a fixed number of frames so that the output settles before real data is released.

Top module: `fsync_ratio_mon`

## Requirements
- R1: After reset with slave operation enabled, `locked` is 0, `mute` is 1, `ratio_code` is 0 and both enables are 0.
- R2: Ratio codes are 0 = 256, 1 = 384, 2 = 512 and 3 = 768 system clocks per frame. A period matches a ratio R when |period − R| × B < T × R, where B is the bit clocks per frame (64, or 48 when `bpf48` is 1) and T is 5 for B = 64 or 4 for B = 48. The first edge after reset or re-enable gives no period. Lock is declared at the second consecutive edge whose period matches the same ratio, and `ratio_code` takes that ratio at the same moment.
- R3: Periods that match no ratio keep the block unlocked with `mute` at 1, however many of them arrive.
- R4: While locked, `en128` pulses once every R/128 cycles and `en64` on every second `en128` pulse. Both restart at each frame edge, which gives 128 and 64 pulses in a frame of exactly R cycles. While unlocked, neither enable pulses.
- R5: While locked, a period within the match band of R keeps lock and leaves the mute countdown unchanged.
- R6: While locked, a period outside the match band but within the loss limit keeps lock.
- R7: While locked, lock is lost when |period − R| × B > L × R, where L is 6 for B = 64 or 5 for B = 48. A short frame is judged at its closing edge. A long or missing frame is judged as soon as the running count passes the limit, before any further edge. `mute` rises when lock is lost.
- R8: At each lock `mute` stays 1, and it falls at the 32nd frame edge after the edge that declared lock.
- R9: Setting `bpf48` to 1 switches the match and loss limits to the 48-bit-clock values of R2 and R7.
- R10: While `slave_en` is 0, `locked`, `mute`, `ratio_code` and both enables are 0, and all acquisition history is cleared. After `slave_en` returns to 1, `mute` is 1 and acquisition starts again from a first edge.
- R11: `ratio_code` does not change while `locked` stays 1. After a loss it keeps the last locked ratio until a new lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_clk | input | 1 | Frame clock, synchronous to `clk` |
| bpf48 | input | 1 | 1: 48 bit clocks per frame; 0: 64 |
| slave_en | input | 1 | 1: the frame clock is received and monitored |
| ratio_code | output | 2 | Detected ratio code (see R2) |
| locked | output | 1 | Ratio acquired and frame clock in sync |
| mute | output | 1 | Request to force output samples to zero |
| en128 | output | 1 | Enable at 128 times the sample rate |
| en64 | output | 1 | Enable at 64 times the sample rate |

## Verification
Steady frames of 256, 384, 512 and 768 cycles confirm the ratio codes, the two-frame acquisition and the enable counts per frame. A run of 32+ frames pins the exact frame on which the mute request drops. Frames lengthened and shortened by amounts inside the match band, inside the middle band and beyond the loss limit separate the three zones. The long case shows a loss taken mid-frame, and the short case a loss taken at the closing edge. Frames of 320 cycles show that an unknown period never locks. One frame shift of 76 cycles at 768 is kept with 48 bit clocks per frame but would be lost with 64, which shows that the limits follow the frame format. Toggling slave operation shows the idle state and a fresh acquisition.

// File: rtl/rlock_pkg.sv
package rlock_pkg;

    localparam int unsigned EN_UNIT    = 128;
    localparam int unsigned NUM_RATIOS = 4;

    // Enable divide factor (system clocks per 128x-rate tick) for each ratio code
    function automatic int unsigned ratio_mult(input logic [1:0] code);
        case (code)
            2'd0:    return 2;
            2'd1:    return 3;
            2'd2:    return 4;
            default: return 6;
        endcase
    endfunction

    // System clocks per frame for each ratio code
    function automatic int unsigned ratio_clocks(input logic [1:0] code);
        return ratio_mult(code) * EN_UNIT;
    endfunction

endpackage

// File: rtl/rlock_period.sv
module rlock_period #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          frame_in,
    output logic          edge_o,
    output logic [CW-1:0] period_o
);
    typedef struct packed {
        logic          f1;
        logic          f2;
        logic [CW-1:0] cnt;
    } st_t;

    st_t q, d;

    always_comb begin
        d    = q;
        d.f1 = frame_in;
        d.f2 = q.f1;
        if (clr)
            d.cnt = '0;
        else if (q.f1 && !q.f2)
            d.cnt = CW'(1);
        else if (q.cnt != '1)
            d.cnt = q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign edge_o   = q.f1 & ~q.f2;
    assign period_o = q.cnt;

    // R2: the period count restarts at one right after every rising frame edge
    a_r2_period_restart: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o && !clr |=> period_o == CW'(1));

endmodule

// File: rtl/rlock_class.sv
module rlock_class #(
    parameter int CW     = 12,
    parameter int TOL64  = 5,
    parameter int LOSS64 = 6,
    parameter int TOL48  = 4,
    parameter int LOSS48 = 5
) (
    input  logic [CW-1:0] period,
    input  logic [1:0]    ref_code,
    input  logic          bpf48,
    output logic          hit,
    output logic [1:0]    hit_code,
    output logic          over_ref,
    output logic          loss_ref
);
    localparam int SW = CW + 8;
    localparam int NR = rlock_pkg::NUM_RATIOS;

    logic [SW-1:0] bpf_w;
    logic [SW-1:0] tol_k;
    logic [SW-1:0] loss_k;
    logic [NR-1:0] hit_vec;

    assign bpf_w  = bpf48 ? SW'(48) : SW'(64);
    assign tol_k  = bpf48 ? SW'(TOL48) : SW'(TOL64);
    assign loss_k = bpf48 ? SW'(LOSS48) : SW'(LOSS64);

    for (genvar i = 0; i < NR; i++) begin : g_cand
        localparam logic [CW-1:0] RV = CW'(rlock_pkg::ratio_clocks(2'(i)));
        logic [CW-1:0] dev;
        assign dev        = (period > RV) ? period - RV : RV - period;
        assign hit_vec[i] = (SW'(dev) * bpf_w) < (tol_k * SW'(RV));
    end

    always_comb begin
        hit      = |hit_vec;
        hit_code = '0;
        for (int j = NR - 1; j >= 0; j--)
            if (hit_vec[j]) hit_code = 2'(j);
    end

    logic [CW-1:0] ref_clk;
    logic [CW-1:0] ref_dev;

    assign ref_clk  = CW'(rlock_pkg::ratio_clocks(ref_code));
    assign over_ref = period > ref_clk;
    assign ref_dev  = over_ref ? period - ref_clk : ref_clk - period;
    assign loss_ref = (SW'(ref_dev) * bpf_w) > (loss_k * SW'(ref_clk));

endmodule

// File: rtl/rlock_div.sv
module rlock_div #(
    parameter int MW = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic       run,
    input  logic [1:0] code,
    output logic       en128,
    output logic       en64
);
    typedef struct packed {
        logic [MW-1:0] div;
        logic          ph;
    } st_t;

    st_t           q, d;
    logic [MW-1:0] last;
    logic          tick;

    assign last = MW'(rlock_pkg::ratio_mult(code) - 1);
    assign tick = run && (q.div == last);

    always_comb begin
        d = q;
        if (restart) begin
            d.div = '0;
            d.ph  = 1'b0;
        end else if (run) begin
            if (tick) begin
                d.div = '0;
                d.ph  = ~q.ph;
            end else begin
                d.div = q.div + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign en128 = tick;
    assign en64  = tick & q.ph;

    // R4: every ratio divides by at least two, so 128x ticks are never adjacent
    a_r4_en128_gap: assert property (@(posedge clk) disable iff (!rst_n)
        en128 |=> !en128);

endmodule

// File: rtl/fsync_ratio_mon.sv
module fsync_ratio_mon #(
    parameter int CW          = 12,
    parameter int MUTE_FRAMES = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_clk,
    input  logic       bpf48,
    input  logic       slave_en,
    output logic [1:0] ratio_code,
    output logic       locked,
    output logic       mute,
    output logic       en128,
    output logic       en64
);
    localparam int HW = $clog2(MUTE_FRAMES + 1);

    typedef struct packed {
        logic          locked;
        logic          prev_ok;
        logic          cand_ok;
        logic [1:0]    cand_code;
        logic [1:0]    code;
        logic [HW-1:0] hold;
    } st_t;

    st_t           q, d;
    logic          fedge;
    logic [CW-1:0] period;
    logic          hit, over_ref, loss_ref;
    logic [1:0]    hit_code;

    rlock_period #(.CW(CW)) u_period (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (!slave_en),
        .frame_in (frame_clk),
        .edge_o   (fedge),
        .period_o (period)
    );

    rlock_class #(.CW(CW)) u_class (
        .period   (period),
        .ref_code (q.code),
        .bpf48    (bpf48),
        .hit      (hit),
        .hit_code (hit_code),
        .over_ref (over_ref),
        .loss_ref (loss_ref)
    );

    rlock_div u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (fedge),
        .run     (q.locked),
        .code    (q.code),
        .en128   (en128),
        .en64    (en64)
    );

    always_comb begin
        d = q;
        if (!slave_en) begin
            d = '0;
        end else if (q.locked) begin
            if (loss_ref && (fedge || over_ref)) begin
                d.locked  = 1'b0;
                d.cand_ok = 1'b0;
            end else if (fedge && q.hold != '0) begin
                d.hold = q.hold - 1'b1;
            end
        end else if (fedge) begin
            if (!q.prev_ok) begin
                d.prev_ok = 1'b1;
                d.cand_ok = 1'b0;
            end else if (hit) begin
                if (q.cand_ok && q.cand_code == hit_code) begin
                    d.locked  = 1'b1;
                    d.code    = hit_code;
                    d.hold    = HW'(MUTE_FRAMES);
                    d.cand_ok = 1'b0;
                end else begin
                    d.cand_ok   = 1'b1;
                    d.cand_code = hit_code;
                end
            end else begin
                d.cand_ok = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign locked     = q.locked;
    assign ratio_code = q.code;
    assign mute       = slave_en & (!q.locked | (q.hold != '0));

    // R8: a fresh lock always starts with the zero request raised
    a_r8_mute_at_lock: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> mute);

    // R8: the settle countdown never climbs while lock is held
    a_r8_hold_monotone: assert property (@(posedge clk) disable iff (!rst_n)
        q.locked && $past(q.locked) |-> q.hold <= $past(q.hold));

    // R11: the reported ratio holds still for as long as lock lasts
    a_r11_code_stable: assert property (@(posedge clk) disable iff (!rst_n)
        locked && $past(locked) |-> $stable(ratio_code));

    // R7: an edge whose period breaks the loss limit ends the lock
    a_r7_loss_edge: assert property (@(posedge clk) disable iff (!rst_n)
        slave_en && q.locked && fedge && loss_ref |=> !locked);

    // R10: leaving slave operation clears lock and silences the enables
    a_r10_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !slave_en |=> !locked && !en128);

endmodule

// File: tb/tb_fsync_ratio_mon.sv
`timescale 1ns/1ps
module tb_fsync_ratio_mon;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_clk = 1'b0;
    logic       bpf48 = 1'b0;
    logic       slave_en = 1'b1;
    logic       mark = 1'b0;
    logic [1:0] ratio_code;
    logic       locked, mute, en128, en64;

    always #4 clk = ~clk;

    fsync_ratio_mon dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_clk  (frame_clk),
        .bpf48      (bpf48),
        .slave_en   (slave_en),
        .ratio_code (ratio_code),
        .locked     (locked),
        .mute       (mute),
        .en128      (en128),
        .en64       (en64)
    );

    typedef struct {
        bit    lk;
        bit    mu;
        int    code;
        int    c128;
        int    c64;
        string tag;
    } exp_t;

    exp_t sb[$];
    int   checks = 0;
    int   errors = 0;
    int   c128 = 0;
    int   c64 = 0;
    bit   done = 1'b0;

    // Monitor: sample between edges, count enables per frame, compare at each frame mark
    initial begin
        forever begin
            @(posedge clk);
            #2;
            c128 += int'(en128);
            c64  += int'(en64);
            if (mark) begin
                if (sb.size() > 0) begin
                    exp_t e;
                    bit   bad;
                    e   = sb.pop_front();
                    bad = (locked != e.lk) || (mute != e.mu) || (int'(ratio_code) != e.code)
                          || (e.c128 >= 0 && c128 != e.c128) || (e.c64 >= 0 && c64 != e.c64);
                    checks++;
                    if (bad) begin
                        errors++;
                        $display("FAIL %s: locked=%0b mute=%0b code=%0d en128=%0d en64=%0d expected locked=%0b mute=%0b code=%0d en128=%0d en64=%0d",
                                 e.tag, locked, mute, ratio_code, c128, c64,
                                 e.lk, e.mu, e.code, e.c128, e.c64);
                    end
                end
                c128 = 0;
                c64  = 0;
            end
        end
    end

    // Driver: one frame of len cycles, called at a falling clock edge; pushes its expectation
    task automatic frame(input int len, input int slmid, input bit lk, input bit mu,
                         input int code, input int e128, input int e64, input string tag);
        exp_t e;
        frame_clk = 1'b1;
        mark      = 1'b1;
        for (int i = 1; i <= len; i++) begin
            @(negedge clk);
            mark = 1'b0;
            if (i == len / 2) begin
                frame_clk = 1'b0;
                if (slmid >= 0) slave_en = slmid[0];
            end
        end
        e.lk = lk; e.mu = mu; e.code = code; e.c128 = e128; e.c64 = e64; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic direct(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state
        direct(locked == 1'b0, "R1 locked after reset", int'(locked), 0);
        direct(mute == 1'b1, "R1 mute after reset", int'(mute), 1);
        direct(ratio_code == 2'd0, "R1 ratio code after reset", int'(ratio_code), 0);
        direct(en128 == 1'b0 && en64 == 1'b0, "R1 enables after reset", int'(en128), 0);

        // R2 acquisition at 384, R4 enable counts, R8 mute countdown
        frame(384, -1, 0, 1, 0, 0, 0, "R2 first edge gives no period");
        frame(384, -1, 0, 1, 0, 0, 0, "R2 one matching frame is not enough");
        for (int k = 3; k <= 36; k++)
            frame(384, -1, 1, (k <= 34), 1, 128, 64, "R2 R4 R8 lock at 384 with mute countdown");

        // R5 tolerated shifts, R6 middle band
        frame(413, -1, 1, 0, 1, -1, -1, "R5 long shift tolerated");
        frame(355, -1, 1, 0, 1, -1, -1, "R5 long shift tolerated at edge");
        frame(384, -1, 1, 0, 1, 128, 64, "R5 short shift tolerated");
        frame(418, -1, 1, 0, 1, -1, -1, "R6 long middle band keeps lock");
        frame(350, -1, 1, 0, 1, -1, -1, "R6 long middle band at edge");
        frame(384, -1, 1, 0, 1, 128, 64, "R6 short middle band keeps lock");

        // R7 overrun loss, relock, short-frame loss
        frame(424, -1, 0, 1, 1, -1, -1, "R7 R11 overrun drops lock mid-frame");
        frame(384, -1, 0, 1, 1, 0, 0, "R7 no enables after loss");
        frame(384, -1, 0, 1, 1, 0, 0, "R7 first match after loss");
        frame(384, -1, 1, 1, 1, 128, 64, "R7 R8 relock with mute");
        frame(344, -1, 1, 1, 1, -1, -1, "R7 short frame judged at closing edge");
        frame(384, -1, 0, 1, 1, 0, 0, "R7 short frame loss");
        frame(384, -1, 0, 1, 1, 0, 0, "R7 rematch after short loss");
        frame(384, -1, 1, 1, 1, 128, 64, "R7 relock after short loss");

        // R10 idle and re-enable, R3 unknown period
        frame(384, 0, 0, 0, 0, -1, -1, "R10 slave disabled");
        frame(384, -1, 0, 0, 0, 0, 0, "R10 idle ignores frames");
        frame(384, 1, 0, 1, 0, 0, 0, "R10 re-enable raises mute");
        for (int k = 0; k < 4; k++)
            frame(320, -1, 0, 1, 0, 0, 0, "R3 unknown period never locks");

        // R2 at 256 and 512, R7 ratio change
        frame(256, -1, 0, 1, 0, 0, 0, "R2 256 after unknown period");
        frame(256, -1, 0, 1, 0, 0, 0, "R2 256 first match");
        frame(256, -1, 1, 1, 0, 128, 64, "R2 R4 lock at 256");
        frame(512, -1, 0, 1, 0, -1, -1, "R7 ratio change lost mid-frame");
        frame(512, -1, 0, 1, 0, 0, 0, "R2 512 first match");
        frame(512, -1, 1, 1, 2, 128, 64, "R2 R4 lock at 512");
        frame(512, -1, 1, 1, 2, 128, 64, "R11 512 held");

        // R9 48 bit clocks per frame at 768
        bpf48 = 1'b1;
        frame(768, -1, 0, 1, 2, -1, -1, "R9 overrun from 512");
        frame(768, -1, 0, 1, 2, 0, 0, "R9 768 first match");
        frame(768, -1, 1, 1, 3, 128, 64, "R2 R4 R9 lock at 768");
        frame(844, -1, 1, 1, 3, -1, -1, "R9 shift 76 kept with 48 bit clocks");
        frame(768, -1, 1, 1, 3, 128, 64, "R9 middle band kept at edge");
        frame(831, -1, 1, 1, 3, -1, -1, "R9 shift 63 tolerated");
        frame(768, -1, 1, 1, 3, 128, 64, "R9 tolerated at edge");
        frame(853, -1, 0, 1, 3, -1, -1, "R7 R9 shift 85 lost with 48 bit clocks");

        // closing mark so the last frame is compared
        frame_clk = 1'b1;
        mark      = 1'b1;
        @(negedge clk);
        mark = 1'b0;
        repeat (6) @(negedge clk);
        if (sb.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL scoreboard: %0d items left, expected 0", sb.size());
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1600000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule